// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block lets a processor read serial NOR flash as if it were ordinary memory. A read request on a valid/ready port carries a bus address inside a flash window. The window is cut into equal regions, one per chip select. The bits above the region size pick the device, and the bits below form the flash byte address.

For each accepted request, the block selects one device and sends a read opcode, an address and an optional dummy gap. It then clocks in a burst of data that is aligned to the burst size and contains the requested word. It returns that 32-bit word and releases chip select. Only one fetch is in flight at a time, and nothing is kept between fetches.

All protocol choices come from one 32-bit configuration register: the opcode, the line count, the address length, the dummy length and the burst size. Setting the register's lock bit freezes it until reset. The serial clock runs at half the system clock. Outputs change while the serial clock is low, and inputs are sampled at the end of its high phase.

Top module: `spi_flash_window`

## Requirements
- R1: The configuration register resets to 0x0000_0003. Its fields are: read opcode [7:0], line mode [9:8], dummy count [13:12], address size [17:16], burst size [25:24] and lock [31]. All other bits read as zero.
- R2: While the lock bit (bit 31) is 1, configuration writes have no effect. Only reset clears the lock.
- R3: The request address bits [WIN_BITS +: log2(NUM_CS)] select the device. During a fetch, exactly that device's chip select (active low) is low and all others stay high. The serial clock pulses only while a chip select is low.
- R4: A fetch begins with 8 serial clocks that carry the opcode MSB first. The opcode is always driven on line 0 alone.
- R5: The address follows the opcode, MSB first. An address size of 0 sends 3 bytes, which are the low 24 bits of the flash address. Any other value sends 4 bytes. The address sent is the flash address rounded down to the burst size.
- R6: Line mode 0 uses one line: the block drives line 0 and samples line 1. Mode 1 uses lines 1:0. Modes 2 and 3 use lines 3:0. In every mode, line index order matches bit significance. The mode applies to address, dummy and data.
- R7: The dummy field value is a count of dummy bytes. Each byte lasts 8/lines serial clocks, and no line is driven during them. A value of 0 skips the gap.
- R8: Burst size 0 fetches 4 bytes, 1 fetches 8, and 2 or 3 fetch 16. Data are received MSB first with no line driven.
- R9: The response holds the requested word of the burst in little-endian form: the first byte received for that word sits in bits [7:0]. rsp_valid is high for one cycle with all chip selects high, and req_ready returns the next cycle.
- R10: req_ready stays low from the cycle after a request is accepted until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration value |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | WIN_BITS+log2(NUM_CS) | Byte address in the flash window |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Returned word |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_out | output | 4 | Serial data out, per line |
| spi_io_oe | output | 4 | Output enable, per line |
| spi_io_in | input | 4 | Serial data in, per line |

## Verification
A flash model in the bench records the opcode, the address and the number of serial clocks on each fetch, and serves bytes derived from the address it received.

Directed fetches cover every line mode, both address sizes, every dummy count, every burst size, and the lowest and highest word of a burst. Together they separate a wrong line mapping, a wrong gap length and a wrong word pick. A 3-byte fetch above 16 MB shows that the address is truncated. A long run of random configurations and addresses mixes these dimensions and also exercises the device decode.

The lock sequence writes a locked value, tries an overwrite, observes the opcode actually sent, then resets, which shows that only reset frees the register.

// File: rtl/spi_win_pkg.sv
package spi_win_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic [7:0] opcode;
    logic [1:0] mode;
    logic [1:0] dummy;
    logic [1:0] asz;
    logic [1:0] burst;
  } rd_cfg_t;

  localparam logic [31:0] CFG_FIELD_MASK = 32'h8303_33FF;
  localparam logic [31:0] CFG_RESET      = 32'h0000_0003;

  function automatic rd_cfg_t unpack_cfg(input logic [31:0] r);
    rd_cfg_t c;
    c.opcode = r[7:0];
    c.mode   = r[9:8];
    c.dummy  = r[13:12];
    c.asz    = r[17:16];
    c.burst  = r[25:24];
    return c;
  endfunction

  // log2 of the number of data lines
  function automatic logic [1:0] lines_log2(input logic [1:0] mode);
    return (mode == 2'd0) ? 2'd0 : (mode == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [2:0] addr_bytes(input logic [1:0] asz);
    return (asz == 2'd0) ? 3'd3 : 3'd4;
  endfunction

  function automatic logic [4:0] burst_bytes(input logic [1:0] b);
    case (b)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // serial clocks needed to move nbytes over 2**lg lines
  function automatic logic [7:0] seg_clocks(input logic [4:0] nbytes, input logic [1:0] lg);
    logic [7:0] bits;
    bits = {nbytes, 3'b000};
    return bits >> lg;
  endfunction

  function automatic logic [127:0] shift_in(input logic [127:0] rx, input logic [3:0] io,
                                            input logic [1:0] lg);
    case (lg)
      2'd0:    return {rx[126:0], io[1]};
      2'd1:    return {rx[125:0], io[1:0]};
      default: return {rx[123:0], io[3:0]};
    endcase
  endfunction

  // received byte k sits at rx[8*(nbytes-1-k) +: 8]
  function automatic logic [31:0] pick_word(input logic [127:0] rx, input logic [4:0] nbytes,
                                            input logic [1:0] woff);
    logic [31:0] w;
    int k;
    w = '0;
    for (int i = 0; i < 4; i++) begin
      k = int'(nbytes) - 1 - (int'(woff) * 4 + i);
      if (k >= 0) w[8*i +: 8] = rx[8*k +: 8];
    end
    return w;
  endfunction

endpackage

// File: rtl/spi_win_cfg.sv
module spi_win_cfg
  import spi_win_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [31:0] cfg_q;
  logic        locked;

  assign locked = cfg_q[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (we && !locked) cfg_q <= wdata & CFG_FIELD_MASK;
  end

  assign rdata = cfg_q;
endmodule

// File: rtl/spi_win_decode.sv
module spi_win_decode
  import spi_win_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int WIN_BITS = 27,
  localparam int CSW     = $clog2(NUM_CS),
  localparam int AW      = WIN_BITS + CSW
) (
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     burst,
  output logic [CSW-1:0] cs_sel,
  output logic [31:0]    fetch_addr,
  output logic [1:0]     woff
);
  logic [31:0] flash_addr;
  logic [31:0] mask;
  logic [31:0] in_burst;

  assign cs_sel     = addr[WIN_BITS +: CSW];
  assign flash_addr = 32'(addr[WIN_BITS-1:0]);
  assign mask       = 32'(burst_bytes(burst)) - 32'd1;
  assign fetch_addr = flash_addr & ~mask;
  assign in_burst   = flash_addr & mask;
  assign woff       = in_burst[3:2];
endmodule

// File: rtl/spi_win_seq.sv
module spi_win_seq
  import spi_win_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int CSW   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rd_cfg_t           cfg,
  input  logic [31:0]       fetch_addr,
  input  logic [1:0]        woff,
  input  logic [CSW-1:0]    cs_sel,
  output logic              idle,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in,
  output logic              seg_cmd,
  output logic              seg_dummy,
  output logic              seg_data
);
  seq_state_t     st;
  logic           ph;
  logic [7:0]     cnt;
  logic [31:0]    tx_sr;
  logic [127:0]   rx_sr;
  rd_cfg_t        cfg_q;
  logic [31:0]    addr_q;
  logic [1:0]     woff_q;
  logic [CSW-1:0] cs_q;

  logic [1:0] lg_q;
  logic [2:0] nab_q;
  logic [4:0] nbytes_q;
  logic [2:0] shamt;
  logic       active;

  assign lg_q     = lines_log2(cfg_q.mode);
  assign nab_q    = addr_bytes(cfg_q.asz);
  assign nbytes_q = burst_bytes(cfg_q.burst);
  assign shamt    = 3'd1 << lg_q;

  assign active    = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_DUMMY) || (st == ST_DATA);
  assign idle      = (st == ST_IDLE);
  assign done      = (st == ST_DONE);
  assign seg_cmd   = (st == ST_CMD);
  assign seg_dummy = (st == ST_DUMMY);
  assign seg_data  = (st == ST_DATA);
  assign sclk      = active && ph;
  assign rdata     = pick_word(rx_sr, nbytes_q, woff_q);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(active && (cs_q == CSW'(g)));
  end

  always_comb begin
    io_out = 4'b0000;
    io_oe  = 4'b0000;
    if (st == ST_CMD) begin
      io_out = {3'b000, tx_sr[31]};
      io_oe  = 4'b0001;
    end else if (st == ST_ADDR) begin
      case (lg_q)
        2'd0: begin io_out = {3'b000, tx_sr[31]};    io_oe = 4'b0001; end
        2'd1: begin io_out = {2'b00, tx_sr[31:30]};  io_oe = 4'b0011; end
        default: begin io_out = tx_sr[31:28];        io_oe = 4'b1111; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ph     <= 1'b0;
      cnt    <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      cfg_q  <= '0;
      addr_q <= '0;
      woff_q <= '0;
      cs_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            cfg_q  <= cfg;
            addr_q <= fetch_addr;
            woff_q <= woff;
            cs_q   <= cs_sel;
            tx_sr  <= {cfg.opcode, 24'h000000};
            cnt    <= 8'd8;
            ph     <= 1'b0;
            st     <= ST_CMD;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: begin
          ph <= ~ph;
          if (ph) begin
            if (st == ST_DATA) rx_sr <= shift_in(rx_sr, io_in, lg_q);
            if (cnt == 8'd1) begin
              case (st)
                ST_CMD: begin
                  st    <= ST_ADDR;
                  cnt   <= seg_clocks({2'b00, nab_q}, lg_q);
                  tx_sr <= (nab_q == 3'd4) ? addr_q : {addr_q[23:0], 8'h00};
                end
                ST_ADDR: begin
                  if (cfg_q.dummy != 2'd0) begin
                    st  <= ST_DUMMY;
                    cnt <= seg_clocks({3'b000, cfg_q.dummy}, lg_q);
                  end else begin
                    st  <= ST_DATA;
                    cnt <= seg_clocks(nbytes_q, lg_q);
                  end
                end
                ST_DUMMY: begin
                  st  <= ST_DATA;
                  cnt <= seg_clocks(nbytes_q, lg_q);
                end
                default: st <= ST_DONE;
              endcase
            end else begin
              cnt   <= cnt - 8'd1;
              tx_sr <= (st == ST_CMD) ? (tx_sr << 1) : (tx_sr << shamt);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_window.sv
module spi_flash_window
  import spi_win_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int WIN_BITS = 27,
  localparam int CSW     = $clog2(NUM_CS),
  localparam int AW      = WIN_BITS + CSW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              spi_sclk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);
  rd_cfg_t        live_cfg;
  logic [CSW-1:0] cs_sel;
  logic [31:0]    fetch_addr;
  logic [1:0]     woff;
  logic           seq_idle;
  logic           accept;
  logic           seg_cmd;
  logic           seg_dummy;
  logic           seg_data;

  spi_win_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata)
  );

  assign live_cfg = unpack_cfg(cfg_rdata);

  spi_win_decode #(.NUM_CS(NUM_CS), .WIN_BITS(WIN_BITS)) u_dec (
    .addr       (req_addr),
    .burst      (live_cfg.burst),
    .cs_sel     (cs_sel),
    .fetch_addr (fetch_addr),
    .woff       (woff)
  );

  assign req_ready = seq_idle;
  assign accept    = req_valid && seq_idle;

  spi_win_seq #(.NUM_CS(NUM_CS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .cfg        (live_cfg),
    .fetch_addr (fetch_addr),
    .woff       (woff),
    .cs_sel     (cs_sel),
    .idle       (seq_idle),
    .done       (rsp_valid),
    .rdata      (rsp_data),
    .sclk       (spi_sclk),
    .cs_n       (spi_cs_n),
    .io_out     (spi_io_out),
    .io_oe      (spi_io_oe),
    .io_in      (spi_io_in),
    .seg_cmd    (seg_cmd),
    .seg_dummy  (seg_dummy),
    .seg_data   (seg_data)
  );
endmodule

// File: rtl/spi_win_checker.sv
module spi_win_checker
  import spi_win_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic [3:0]        io_oe,
  input logic              seg_cmd,
  input logic              seg_dummy,
  input logic              seg_data
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~CFG_FIELD_MASK) == 32'h0);

  assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31] |=> $stable(cfg_rdata));

  assert_one_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_sclk_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !(&cs_n));

  assert_cmd_line0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_cmd |-> (io_oe == 4'b0001));

  assert_dummy_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_dummy |-> (io_oe == 4'b0000));

  assert_data_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_data |-> (io_oe == 4'b0000));

  assert_rsp_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&cs_n));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind spi_flash_window spi_win_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sclk      (spi_sclk),
  .cs_n      (spi_cs_n),
  .io_oe     (spi_io_oe),
  .seg_cmd   (seg_cmd),
  .seg_dummy (seg_dummy),
  .seg_data  (seg_data)
);

// File: tb/tb_spi_flash_window.sv
`timescale 1ns/1ps
module tb_spi_flash_window;
  localparam int NUM_CS   = 2;
  localparam int WIN_BITS = 27;
  localparam int CSW      = 1;
  localparam int AW       = WIN_BITS + CSW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [AW-1:0]     req_addr = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_data;
  logic              spi_sclk;
  logic [NUM_CS-1:0] spi_cs_n;
  logic [3:0]        spi_io_out;
  logic [3:0]        spi_io_oe;
  logic [3:0]        spi_io_in;

  always #2 clk = ~clk;

  spi_flash_window #(.NUM_CS(NUM_CS), .WIN_BITS(WIN_BITS)) dut (.*);

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // current configuration as the bench sees it
  logic [7:0] c_op;
  int c_mode, c_asz, c_dum, c_burst;
  int c_lines, c_nab, a_clk, d_clk;

  // flash model state
  int          rises;
  logic [7:0]  m_cmd;
  logic [31:0] m_addr;
  int          m_cs;

  function automatic logic [7:0] mem_byte(input int cs, input logic [31:0] a);
    logic [31:0] t;
    t = (a * 32'd2654435761) ^ (32'(cs) * 32'h0000_9E37);
    return t[23:16] ^ t[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic set_cfg(input logic [7:0] op, input int mode, input int asz,
                         input int dum, input int burst, input bit lock);
    c_op = op; c_mode = mode; c_asz = asz; c_dum = dum; c_burst = burst;
    c_lines = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
    c_nab   = (asz == 0) ? 3 : 4;
    a_clk   = c_nab * 8 / c_lines;
    d_clk   = dum * 8 / c_lines;
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {lock, 5'b0, 2'(burst), 6'b0, 2'(asz), 2'b0, 2'(dum), 2'b0, 2'(mode), op};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // flash model: capture on rising clock
  initial forever begin
    @(posedge spi_sclk);
    if (rises == 0)
      for (int c = 0; c < NUM_CS; c++) if (!spi_cs_n[c]) m_cs = c;
    if (rises < 8) m_cmd = {m_cmd[6:0], spi_io_out[0]};
    else if (rises < 8 + a_clk)
      m_addr = (m_addr << c_lines) | 32'(spi_io_out & 4'((1 << c_lines) - 1));
    rises++;
  end

  // flash model: drive on falling clock
  initial begin
    spi_io_in = 4'b0;
    forever begin
      @(negedge spi_sclk);
      if (rises >= 8 + a_clk + d_clk) begin
        int p, j, b;
        logic [7:0] byt;
        logic [3:0] drv;
        p = (rises - 8 - a_clk - d_clk) * c_lines;
        j = p / 8;
        b = 7 - (p % 8);
        byt = mem_byte(m_cs, m_addr + 32'(j));
        drv = 4'b0;
        for (int i = 0; i < c_lines; i++) drv[c_lines-1-i] = byt[b-i];
        spi_io_in = (c_lines == 1) ? {2'b00, drv[0], 1'b0} : drv;
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a);
    int cs, bb, clocks, t;
    logic [31:0] flash, fa, off, exp_w;
    cs     = int'(a[WIN_BITS +: CSW]);
    flash  = 32'(a[WIN_BITS-1:0]);
    bb     = (c_burst == 0) ? 4 : (c_burst == 1) ? 8 : 16;
    fa     = flash & ~32'(bb - 1);
    off    = flash & 32'(bb - 1) & ~32'd3;
    if (c_nab == 3) fa = fa & 32'h00FF_FFFF;
    clocks = 8 + (c_nab * 8 + c_dum * 8 + bb * 8) / c_lines;
    for (int i = 0; i < 4; i++) exp_w[8*i +: 8] = mem_byte(cs, fa + off + 32'(i));
    rises = 0; m_cmd = '0; m_addr = '0; m_cs = -1;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    t = 0;
    while (!req_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready low while busy", 32'(req_ready), 32'd0);
    t = 0;
    while (!rsp_valid && t < 4000) begin @(negedge clk); t++; end
    chk(rsp_valid == 1'b1, "R9", "response arrives", 32'(rsp_valid), 32'd1);
    chk(rsp_data == exp_w, "R9 R8", "returned word", rsp_data, exp_w);
    chk(&spi_cs_n, "R9", "cs released at response", 32'(spi_cs_n), 32'(2**NUM_CS - 1));
    chk(m_cmd == c_op, "R4", "opcode on line 0", 32'(m_cmd), 32'(c_op));
    chk(m_addr == fa, "R5 R6", "address sent", m_addr, fa);
    chk(m_cs == cs, "R3", "selected device", 32'(m_cs), 32'(cs));
    chk(rises == clocks, "R7 R8", "serial clock count", 32'(rises), 32'(clocks));
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R9", "single-cycle response then ready",
        {30'b0, req_ready, rsp_valid}, 32'h2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    c_op = 8'h03; c_mode = 0; c_asz = 0; c_dum = 0; c_burst = 0;
    c_lines = 1; c_nab = 3; a_clk = 24; d_clk = 0; rises = 0;
    m_cmd = '0; m_addr = '0; m_cs = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 32'h0000_0003, "R1", "config reset value", cfg_rdata, 32'h3);
    chk(&spi_cs_n && !spi_sclk && spi_io_oe == 4'b0, "R3", "idle pins",
        {spi_io_oe, 1'b0, spi_sclk, 2'(spi_cs_n)}, 32'h3);
    chk(req_ready && !rsp_valid, "R10", "idle handshake", {30'b0, req_ready, rsp_valid}, 32'h2);

    // R1 reserved bits
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h7FFF_FFFF;
    @(negedge clk); cfg_we = 1'b0;
    chk(cfg_rdata == 32'h0303_33FF, "R1", "field mask", cfg_rdata, 32'h0303_33FF);

    // directed corner cases
    set_cfg(8'h03, 0, 0, 0, 0, 1'b0);  do_read(28'h000_0104);
    set_cfg(8'hEB, 2, 1, 3, 3, 1'b0);  do_read({1'b1, 27'h7FF_FFFC});
    set_cfg(8'hEB, 2, 1, 3, 3, 1'b0);  do_read({1'b0, 27'h123_4560});
    set_cfg(8'hBB, 1, 0, 1, 1, 1'b0);  do_read({1'b1, 27'h00A_BC0C});
    set_cfg(8'h6B, 3, 1, 2, 2, 1'b0);  do_read({1'b0, 27'h055_5558});
    set_cfg(8'h0B, 0, 0, 1, 3, 1'b0);  do_read({1'b1, 27'h5AB_CDE8}); // R5 24-bit truncation
    set_cfg(8'h3B, 1, 1, 2, 0, 1'b0);  do_read({1'b0, 27'h000_0000});

    // random mix
    for (int n = 0; n < 40; n++) begin
      set_cfg(8'($urandom), int'($urandom % 4), int'($urandom % 2), int'($urandom % 4),
              int'($urandom % 4), 1'b0);
      do_read(AW'($urandom));
    end

    // R2 lock
    set_cfg(8'h0B, 2, 1, 1, 3, 1'b1);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h0000_0003;
    @(negedge clk); cfg_we = 1'b0;
    chk(cfg_rdata == 32'h8301_120B, "R2", "locked value kept", cfg_rdata, 32'h8301_120B);
    do_read({1'b1, 27'h000_2224});
    // R2 only reset unlocks
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 32'h0000_0003, "R2", "reset clears lock", cfg_rdata, 32'h3);
    set_cfg(8'h13, 1, 1, 0, 2, 1'b0);
    chk(cfg_rdata == 32'h0201_0113, "R2", "write after reset", cfg_rdata, 32'h0201_0113);
    do_read({1'b0, 27'h7FF_FFF0});

    report();
  end
endmodule